// File: doc/BRIEF.md
# Run-Length Counter with Carry-Bit Terminal Detect

This block times a run of clock cycles whose length comes from an n-bit operand. A load strobe captures the operand into a counter that is one bit wider than the operand. Each enabled cycle then advances the counter by one step. The run ends when that extra top bit changes state. Because only this one bit is watched, the end of the run needs no n-bit equality compare. The adder's carry (or borrow) into the top bit does the work.

The direction is fixed at build time. In the upward variant the load places the inverted operand under a set top bit, and the counter increments until it wraps to zero. In the downward variant the load places the operand itself under a cleared top bit, and the counter decrements until it passes below zero. Both variants take exactly one step more than the operand value. When the run ends, a done flag is high for one clock and the counter parks until the next load.

Top module: `tc_counter`

## Requirements
- R1: Under reset the count output is all zeros and done is low. After reset, enable has no effect until the first load.
- R2: The count output is WIDTH+1 bits wide, so an operand of 2^WIDTH-1 runs for 2^WIDTH steps without losing the end of the run.
- R3: In the upward variant (DIR = TC_UP), a load puts the bitwise inverse of the operand in count bits [WIDTH-1:0] and sets bit [WIDTH] to 1.
- R4: In the downward variant (DIR = TC_DOWN), a load puts the operand in count bits [WIDTH-1:0] and clears bit [WIDTH] to 0.
- R5: In the upward variant, the run ends when bit [WIDTH] falls to 0. At that point the count is all zeros.
- R6: In the downward variant, the run ends when bit [WIDTH] rises to 1. At that point the count is all ones.
- R7: With an operand M, done goes high in the clock that follows the (M+1)-th enabled rising edge after the load edge.
- R8: A cycle with enable low and no load leaves the count unchanged and does not end the run.
- R9: Done is high for exactly one clock per completed run.
- R10: After the run ends, the count holds its final value, whatever enable does, until the next load.
- R11: When load and enable are both high in the same cycle, the load takes effect and no step is taken.
- R12: A load during a run abandons that run. No done is produced for it, and the new run is timed from the new load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Captures the operand and starts a run |
| enable | input | 1 | Lets the counter take one step this cycle |
| m_value | input | WIDTH | Run-length operand M |
| count | output | WIDTH+1 | Running counter value |
| done | output | 1 | One-clock pulse when the run ends |

## Verification
The bench runs both variants side by side and times every run from its load edge to the done pulse. The operands are 0, 1, the all-ones value and random values. A design that compared against M, or that lost the extra step, would report runs one cycle short. A design without the extra bit would never end the all-ones run.

Further checks cover the following cases:
- Load and enable high together. A wrong priority shows up as a count one step past the loaded image.
- Enable pauses. A design that stepped anyway would report a run that ends early.
- The parked state after done. A counter that kept stepping would wrap or fire done again.
- A reload in mid-run. A design that kept the old run alive would raise a stray done.

// File: rtl/tc_pkg.sv
package tc_pkg;

    // Counting direction, fixed per instance.
    typedef enum logic {
        TC_UP   = 1'b0,
        TC_DOWN = 1'b1
    } tc_dir_e;

    // Control state carried beside the counter value.
    typedef struct packed {
        logic busy;
        logic done;
    } tc_flags_t;

    localparam tc_flags_t TC_FLAGS_IDLE = '{busy: 1'b0, done: 1'b0};

    // Value of the extra top bit while a run is in progress.
    function automatic logic run_msb(tc_dir_e dir);
        return (dir == TC_UP) ? 1'b1 : 1'b0;
    endfunction

    // Value of the extra top bit once the run has ended.
    function automatic logic end_msb(tc_dir_e dir);
        return ~run_msb(dir);
    endfunction

endpackage

// File: rtl/tc_load_image.sv
module tc_load_image
    import tc_pkg::*;
#(
    parameter int      WIDTH = 8,
    parameter tc_dir_e DIR   = TC_UP
) (
    input  logic [WIDTH-1:0] m_value,
    output logic [WIDTH:0]   image
);
    generate
        if (DIR == TC_UP) begin : g_up
            // Inverted operand under a set top bit: M+1 increments reach zero.
            assign image = {run_msb(DIR), ~m_value};
        end else begin : g_down
            // Operand under a cleared top bit: M+1 decrements reach minus one.
            assign image = {run_msb(DIR), m_value};
        end
    endgenerate
endmodule

// File: rtl/tc_stepper.sv
module tc_stepper
    import tc_pkg::*;
#(
    parameter int      WIDTH = 8,
    parameter tc_dir_e DIR   = TC_UP
) (
    input  logic [WIDTH:0] cur,
    output logic [WIDTH:0] nxt,
    output logic           crossed
);
    localparam logic [WIDTH:0] ONE = {{WIDTH{1'b0}}, 1'b1};

    generate
        if (DIR == TC_UP) begin : g_inc
            assign nxt = cur + ONE;
        end else begin : g_dec
            assign nxt = cur - ONE;
        end
    endgenerate

    // The only end-of-run test: the carry or borrow flips the extra top bit.
    assign crossed = cur[WIDTH] ^ nxt[WIDTH];
endmodule

// File: rtl/tc_ctrl.sv
module tc_ctrl
    import tc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           enable,
    input  logic [WIDTH:0] image,
    input  logic [WIDTH:0] nxt,
    input  logic           crossed,
    output logic [WIDTH:0] cnt_q,
    output tc_flags_t      flags_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            flags_q <= TC_FLAGS_IDLE;
        end else if (load) begin
            // A load takes priority over enable.
            cnt_q        <= image;
            flags_q.busy <= 1'b1;
            flags_q.done <= 1'b0;
        end else if (enable && flags_q.busy) begin
            cnt_q        <= nxt;
            flags_q.busy <= ~crossed;
            flags_q.done <= crossed;
        end else begin
            flags_q.done <= 1'b0;
        end
    end
endmodule

// File: rtl/tc_counter.sv
module tc_counter
    import tc_pkg::*;
#(
    parameter int      WIDTH = 8,
    parameter tc_dir_e DIR   = TC_UP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             enable,
    input  logic [WIDTH-1:0] m_value,
    output logic [WIDTH:0]   count,
    output logic             done
);
    logic [WIDTH:0] image;
    logic [WIDTH:0] nxt;
    logic           crossed;
    logic [WIDTH:0] cnt_q;
    tc_flags_t      flags_q;

    tc_load_image #(.WIDTH(WIDTH), .DIR(DIR)) u_image (
        .m_value (m_value),
        .image   (image)
    );

    tc_stepper #(.WIDTH(WIDTH), .DIR(DIR)) u_step (
        .cur     (cnt_q),
        .nxt     (nxt),
        .crossed (crossed)
    );

    tc_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .enable  (enable),
        .image   (image),
        .nxt     (nxt),
        .crossed (crossed),
        .cnt_q   (cnt_q),
        .flags_q (flags_q)
    );

    assign count = cnt_q;
    assign done  = flags_q.done;
endmodule

// File: rtl/tc_counter_chk.sv
module tc_counter_chk
    import tc_pkg::*;
#(
    parameter int      WIDTH = 8,
    parameter tc_dir_e DIR   = TC_UP
) (
    input logic             clk,
    input logic             rst,
    input logic             load,
    input logic             enable,
    input logic [WIDTH-1:0] m_value,
    input logic [WIDTH:0]   count,
    input logic             done
);
    localparam logic [WIDTH:0] ALL_ONES = '1;
    localparam bit             IS_UP    = (DIR == TC_UP);

    // Set when a run has ended, cleared by the next load.
    logic parked;
    always_ff @(posedge clk) begin
        if (rst || load) parked <= 1'b0;
        else if (done)   parked <= 1'b1;
    end

    p_up_image_r3: assert property (@(posedge clk) disable iff (rst)
        (IS_UP && load) |=> count == {1'b1, ~$past(m_value)});

    p_dn_image_r4: assert property (@(posedge clk) disable iff (rst)
        (!IS_UP && load) |=> count == {1'b0, $past(m_value)});

    p_up_term_r5: assert property (@(posedge clk) disable iff (rst)
        (IS_UP && done) |-> count == '0);

    p_dn_term_r6: assert property (@(posedge clk) disable iff (rst)
        (!IS_UP && done) |-> count == ALL_ONES);

    p_pause_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && !enable) |=> ($stable(count) && !done));

    p_single_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_parked_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (parked && !load) |=> ($stable(count) && !done));

    p_load_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (load && enable) |=> !done);
endmodule

bind tc_counter tc_counter_chk #(.WIDTH(WIDTH), .DIR(DIR)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .enable  (enable),
    .m_value (m_value),
    .count   (count),
    .done    (done)
);

// File: tb/tb_tc_counter.sv
module tb_tc_counter;
    import tc_pkg::*;

    localparam int       W    = 8;
    localparam [W:0]     ONES = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic         enable = 1'b0;
    logic [W-1:0] m = '0;
    logic [W:0]   cnt_up, cnt_dn;
    logic         done_up, done_dn;

    always #10 clk = ~clk;   // 50 MHz

    tc_counter #(.WIDTH(W), .DIR(TC_UP)) dut (
        .clk(clk), .rst(rst), .load(load), .enable(enable),
        .m_value(m), .count(cnt_up), .done(done_up)
    );

    tc_counter #(.WIDTH(W), .DIR(TC_DOWN)) dut_dn (
        .clk(clk), .rst(rst), .load(load), .enable(enable),
        .m_value(m), .count(cnt_dn), .done(done_dn)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errs = 0;
    int checks = 0;
    bit finished = 0;
    int q_up[$];
    int q_dn[$];
    int e_up, e_dn;
    bit prev_up = 0, prev_dn = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected end cycles as done pulses appear.
    always @(negedge clk) begin
        if (!rst) begin
            if (done_up) begin
                if (q_up.size() == 0) chk(0, "R12 up stray done", cyc, -1);
                else begin
                    e_up = q_up.pop_front();
                    chk(cyc == e_up, "R7 up run length", cyc, e_up);
                    chk(cnt_up == '0, "R5 up final count", cnt_up, 0);
                end
            end
            if (done_dn) begin
                if (q_dn.size() == 0) chk(0, "R12 down stray done", cyc, -1);
                else begin
                    e_dn = q_dn.pop_front();
                    chk(cyc == e_dn, "R7 down run length", cyc, e_dn);
                    chk(cnt_dn == ONES, "R6 down final count", cnt_dn, ONES);
                end
            end
            if (done_up && prev_up) chk(0, "R9 up done width", 2, 1);
            if (done_dn && prev_dn) chk(0, "R9 down done width", 2, 1);
            prev_up <= done_up;
            prev_dn <= done_dn;
        end
    end

    // Driver: starts a run with operand val and k paused cycles after the load.
    task automatic run(input int val, input int k);
        int exp_cyc;
        @(negedge clk);
        load = 1'b1; enable = 1'b1; m = W'(val);
        exp_cyc = cyc + val + 2 + k;
        q_up.push_back(exp_cyc);
        q_dn.push_back(exp_cyc);
        @(negedge clk);
        load = 1'b0;
        if (k > 0) begin
            enable = 1'b0;
            repeat (k) @(negedge clk);
            enable = 1'b1;
        end
        repeat (val + 3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cnt_up == '0 && cnt_dn == '0, "R1 reset count", cnt_up | cnt_dn, 0);
        chk(!done_up && !done_dn, "R1 reset done", done_up | done_dn, 0);
        rst = 1'b0;
        enable = 1'b1;
        repeat (5) @(negedge clk);
        chk(cnt_up == '0 && cnt_dn == '0, "R1 idle before load", cnt_up | cnt_dn, 0);

        // R3 / R4: load images
        enable = 1'b0; load = 1'b1; m = 8'h35;
        @(negedge clk);
        load = 1'b0;
        chk(cnt_up == 9'h1CA, "R3 up load image", cnt_up, 9'h1CA);
        chk(cnt_dn == 9'h035, "R4 down load image", cnt_dn, 9'h035);

        // R11: load and enable together
        load = 1'b1; enable = 1'b1; m = 8'h0A;
        @(negedge clk);
        load = 1'b0; enable = 1'b0;
        chk(cnt_up == 9'h1F5, "R11 up load wins", cnt_up, 9'h1F5);
        chk(cnt_dn == 9'h00A, "R11 down load wins", cnt_dn, 9'h00A);

        // R8: pause holds, then a single step
        repeat (3) @(negedge clk);
        chk(cnt_up == 9'h1F5, "R8 up paused", cnt_up, 9'h1F5);
        chk(cnt_dn == 9'h00A, "R8 down paused", cnt_dn, 9'h00A);
        enable = 1'b1;
        @(negedge clk);
        enable = 1'b0;
        chk(cnt_up == 9'h1F6, "R8 up one step", cnt_up, 9'h1F6);
        chk(cnt_dn == 9'h009, "R8 down one step", cnt_dn, 9'h009);

        // R12: the run above is abandoned by the next load
        run(0, 0);
        run(1, 0);
        run(2, 0);
        run(255, 0);   // R2: full-range operand needs the extra bit
        run(5, 3);     // R8: pauses stretch the run
        run(17, 1);

        // R10: parked after the end, enable has no effect
        enable = 1'b1;
        repeat (5) @(negedge clk);
        chk(cnt_up == '0 && !done_up, "R10 up parked", cnt_up, 0);
        chk(cnt_dn == ONES && !done_dn, "R10 down parked", cnt_dn, ONES);

        // R12: reload mid-run
        @(negedge clk);
        load = 1'b1; m = 8'd40;
        @(negedge clk);
        load = 1'b0;
        repeat (6) @(negedge clk);
        run(3, 0);

        for (int i = 0; i < 8; i++) run($urandom_range(0, 255), i % 3);

        repeat (4) @(negedge clk);
        chk(q_up.size() == 0, "R7 up missing done", q_up.size(), 0);
        chk(q_dn.size() == 0, "R7 down missing done", q_dn.size(), 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end
endmodule